// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block is a small programmable sum-of-products array at register-transfer level. A vector of logic inputs drives a plane of product terms. Each term can require any input to be high, to be low, or leave it out. A second plane picks which terms are ORed into each output. An inversion bit per output turns a sum of products into a product of sums.

A mode input fixes the OR plane. In that mode each output takes its own equal group of adjacent product terms, and only the AND plane and the inversion bits matter. The configuration is written one row per write through a word-wide port, and only while the evaluate input is low. The outputs stay at zero until every row has been written at least once. The result is registered.

The product-term rows are the scarce resource. A write whose address is past the last row is refused and reported.

Top module: `sop_logic_array`

## Requirements
- R1: Addresses 0..NUM_TERMS-1 select product-term rows. In a term row, data bit i connects input i in true form and data bit NUM_IN+i connects input i in complemented form. A term is high when every connected literal is satisfied.
- R2: A term row with no literal connected evaluates to 1. A term row that connects an input in both forms evaluates to 0.
- R3: Addresses NUM_TERMS..NUM_TERMS+NUM_OUT-1 select output rows, in output order. In full mode (palMode=0), bit k of an output row connects term k to that output. An output row with no term connected yields 0 before inversion.
- R4: With palMode=1, output o is the OR of terms o*TPO..o*TPO+TPO-1, where TPO=NUM_TERMS/NUM_OUT. The stored output-row term bits have no effect.
- R5: Bit NUM_TERMS of an output row inverts that output.
- R6: After reset cfgValid is 0. It rises after every row has been written at least once and then stays high. While cfgValid is 0, dataOut is 0.
- R7: A write is ignored while evalEn is high. The stored configuration and cfgErr are unchanged.
- R8: A write with evalEn low to an address at or above NUM_TERMS+NUM_OUT changes no row. It raises cfgErr for exactly the following cycle.
- R9: dataOut loads the evaluated result at each clock edge where evalEn is high and cfgValid is 1. When evalEn is low, dataOut holds its value.
- R10: With inputs A=in[0], B=in[1], C=in[2], four terms A·B, A·C', A·B', B·C', and outputs X=terms 0,1 and Y=terms 2,3, the array produces X=A·B+A·C' and Y=A·B'+B·C' for all eight input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evalEn | input | 1 | Evaluate enable; blocks configuration writes while high |
| palMode | input | 1 | 1 selects the fixed OR plane |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W | Row address of the write |
| cfgData | input | DW | Row contents |
| dataIn | input | NUM_IN | Logic inputs |
| dataOut | output | NUM_OUT | Registered array outputs |
| cfgValid | output | 1 | All rows have been written |
| cfgErr | output | 1 | One-cycle flag for a refused out-of-range write |

## Verification
A configuration write is taken at the rising edge where cfgWe is high. Its row affects results from the next evaluation on. cfgValid rises in the cycle after the edge that writes the last missing row. cfgErr is high for exactly the one cycle after an out-of-range write edge. dataOut carries the function of the inputs presented at the edge where evalEn was high.

The bench changes every input just after a falling edge. It then reads the outputs at the next falling edge, one rising edge later, which is exactly where each of these results is due. The hold check presents new inputs with evalEn low and reads dataOut one edge later. That way the old value is seen at the only point where it could have changed.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

  // Write strobes from the configuration control to the datapath
  typedef struct packed {
    logic andWe;  // write a product-term row
    logic orWe;   // write an output row
  } cfgStrobe_t;

endpackage

// File: rtl/sop_cfg_ctrl.sv
module sop_cfg_ctrl
  import sop_array_pkg::*;
#(
  parameter int NUM_TERMS = 4,
  parameter int NUM_OUT   = 2,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalEn,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output cfgStrobe_t        strobe,
  output logic [ADDR_W-1:0] rowIdx,
  output logic              cfgValid,
  output logic              cfgErr
);

  localparam int ROWS = NUM_TERMS + NUM_OUT;

  logic            accept;
  logic            isTermRow;
  logic            inRange;
  logic            errPulse;
  logic [ROWS-1:0] writtenQ;

  always_comb begin
    accept    = cfgWe && !evalEn;
    isTermRow = cfgAddr < ADDR_W'(NUM_TERMS);
    inRange   = cfgAddr < ADDR_W'(ROWS);
    strobe.andWe = accept && isTermRow;
    strobe.orWe  = accept && inRange && !isTermRow;
    errPulse     = accept && !inRange;
    rowIdx = isTermRow ? cfgAddr : (cfgAddr - ADDR_W'(NUM_TERMS));
  end

  // Track which rows have seen at least one accepted write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writtenQ <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (accept && cfgAddr == ADDR_W'(r)) writtenQ[r] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= errPulse;
  end

  assign cfgValid = &writtenQ;

endmodule

// File: rtl/sop_eval_path.sv
module sop_eval_path
  import sop_array_pkg::*;
#(
  parameter int NUM_IN    = 3,
  parameter int NUM_TERMS = 4,
  parameter int NUM_OUT   = 2,
  parameter int ADDR_W    = 4,
  parameter int DW        = 6,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  rowIdx,
  input  logic [DW-1:0]      cfgData,
  input  logic               palMode,
  input  logic               evalEn,
  input  logic               cfgValid,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);

  localparam int TPO = NUM_TERMS / NUM_OUT;

  logic [NUM_TERMS-1:0][NUM_IN-1:0]  andTrueQ;
  logic [NUM_TERMS-1:0][NUM_IN-1:0]  andInvQ;
  logic [NUM_OUT-1:0][NUM_TERMS-1:0] orMaskQ;
  logic [NUM_OUT-1:0]                orInvQ;
  logic [NUM_TERMS-1:0]              termHit;
  logic [NUM_OUT-1:0]                sumBit;

  // Configuration rows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      andTrueQ <= '0;
      andInvQ  <= '0;
      orMaskQ  <= '0;
      orInvQ   <= '0;
    end else begin
      for (int t = 0; t < NUM_TERMS; t++) begin
        if (strobe.andWe && rowIdx == ADDR_W'(t)) begin
          andTrueQ[t] <= cfgData[NUM_IN-1:0];
          andInvQ[t]  <= cfgData[2*NUM_IN-1:NUM_IN];
        end
      end
      for (int o = 0; o < NUM_OUT; o++) begin
        if (strobe.orWe && rowIdx == ADDR_W'(o)) begin
          orMaskQ[o] <= cfgData[NUM_TERMS-1:0];
          orInvQ[o]  <= cfgData[NUM_TERMS];
        end
      end
    end
  end

  // AND plane: a term is high when all connected literals are satisfied
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    always_comb begin
      termHit[t] = ((dataIn & andTrueQ[t]) == andTrueQ[t]) &&
                   ((~dataIn & andInvQ[t]) == andInvQ[t]);
    end
  end

  // OR plane: programmable or fixed grouping, then optional inversion
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [NUM_TERMS-1:0] fixedMask;
    logic [NUM_TERMS-1:0] useMask;
    always_comb begin
      for (int k = 0; k < NUM_TERMS; k++) begin
        fixedMask[k] = ((k / TPO) == o);
      end
      useMask   = palMode ? fixedMask : orMaskQ[o];
      sumBit[o] = (|(termHit & useMask)) ^ orInvQ[o];
    end
  end

  if (REG_OUT) begin : g_reg_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         dataOut <= '0;
      else if (!cfgValid) dataOut <= '0;
      else if (evalEn)    dataOut <= sumBit;
    end
  end else begin : g_comb_out
    assign dataOut = (cfgValid && evalEn) ? sumBit : '0;
  end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_array_pkg::*;
#(
  parameter int NUM_IN    = 3,
  parameter int NUM_TERMS = 4,
  parameter int NUM_OUT   = 2,
  parameter bit REG_OUT   = 1'b1,
  localparam int ROWS     = NUM_TERMS + NUM_OUT,
  localparam int ADDR_W   = $clog2(ROWS) + 1,
  localparam int DW       = (2 * NUM_IN > NUM_TERMS + 1) ? 2 * NUM_IN : NUM_TERMS + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evalEn,
  input  logic               palMode,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DW-1:0]      cfgData,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut,
  output logic               cfgValid,
  output logic               cfgErr
);

  cfgStrobe_t        strobe;
  logic [ADDR_W-1:0] rowIdx;

  sop_cfg_ctrl #(
    .NUM_TERMS(NUM_TERMS),
    .NUM_OUT  (NUM_OUT),
    .ADDR_W   (ADDR_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .evalEn  (evalEn),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .strobe  (strobe),
    .rowIdx  (rowIdx),
    .cfgValid(cfgValid),
    .cfgErr  (cfgErr)
  );

  sop_eval_path #(
    .NUM_IN   (NUM_IN),
    .NUM_TERMS(NUM_TERMS),
    .NUM_OUT  (NUM_OUT),
    .ADDR_W   (ADDR_W),
    .DW       (DW),
    .REG_OUT  (REG_OUT)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rowIdx  (rowIdx),
    .cfgData (cfgData),
    .palMode (palMode),
    .evalEn  (evalEn),
    .cfgValid(cfgValid),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk #(
  parameter int NUM_TERMS = 4,
  parameter int NUM_OUT   = 2,
  parameter int ADDR_W    = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               evalEn,
  input logic               cfgWe,
  input logic [ADDR_W-1:0]  cfgAddr,
  input logic [NUM_OUT-1:0] dataOut,
  input logic               cfgValid,
  input logic               cfgErr
);

  localparam int ROWS = NUM_TERMS + NUM_OUT;

  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid);

  // R6
  zero_until_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> dataOut == '0);

  // R7
  busy_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && evalEn) |=> !cfgErr);

  // R8
  range_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !evalEn && cfgAddr >= ADDR_W'(ROWS)) |=> cfgErr);

  // R8
  err_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> !cfgErr);

  if (REG_OUT) begin : g_hold
    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      !evalEn |=> $stable(dataOut));
  end

endmodule

bind sop_logic_array sop_logic_array_chk #(
  .NUM_TERMS(NUM_TERMS),
  .NUM_OUT  (NUM_OUT),
  .ADDR_W   (ADDR_W),
  .REG_OUT  (REG_OUT)
) chk_i (.*);

// File: tb/sop_logic_array_tb_top.sv
module sop_logic_array_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evalEn = 1'b0;
  logic       palMode = 1'b0;
  logic       cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [5:0] cfgData = '0;
  logic [2:0] dataIn = '0;
  logic [1:0] dataOut;
  logic       cfgValid;
  logic       cfgErr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // bench-side configuration model
  logic [2:0] bTrue [4];
  logic [2:0] bInv  [4];
  logic [3:0] bOr   [2];
  logic       bPol  [2];

  always #5 clk = ~clk;

  sop_logic_array dut_i (
    .clk(clk), .rstN(rstN), .evalEn(evalEn), .palMode(palMode),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .dataIn(dataIn),
    .dataOut(dataOut), .cfgValid(cfgValid), .cfgErr(cfgErr)
  );

  function automatic logic [1:0] expect_out(logic [2:0] x, logic pal);
    logic [3:0] term;
    logic [1:0] res;
    logic [3:0] mask;
    for (int t = 0; t < 4; t++)
      term[t] = ((x & bTrue[t]) == bTrue[t]) && ((~x & bInv[t]) == bInv[t]);
    for (int o = 0; o < 2; o++) begin
      mask = pal ? (4'b0011 << (2 * o)) : bOr[o];
      res[o] = (|(term & mask)) ^ bPol[o];
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [5:0] d, input logic busy);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'(addr); cfgData = d; evalEn = busy;
    @(negedge clk);
    cfgWe = 1'b0; evalEn = 1'b0;
    if (!busy && addr < 4) begin
      bTrue[addr] = d[2:0]; bInv[addr] = d[5:3];
    end else if (!busy && addr < 6) begin
      bOr[addr-4] = d[3:0]; bPol[addr-4] = d[4];
    end
  endtask

  task automatic eval_one(input logic [2:0] x, input logic pal, input string req);
    @(negedge clk);
    dataIn = x; palMode = pal; evalEn = 1'b1;
    @(negedge clk);
    evalEn = 1'b0;
    check(dataOut == expect_out(x, pal), req, dataOut, expect_out(x, pal));
  endtask

  task automatic eval_all(input logic pal, input string req);
    for (int x = 0; x < 8; x++) eval_one(3'(x), pal, req);
  endtask

  task automatic load_reference();
    wr(0, 6'b000_011, 1'b0);  // A·B
    wr(1, 6'b100_001, 1'b0);  // A·C'
    wr(2, 6'b010_001, 1'b0);  // A·B'
    wr(3, 6'b100_010, 1'b0);  // B·C'
    wr(4, 6'b0_0011, 1'b0);   // X = t0 + t1
    wr(5, 6'b0_1100, 1'b0);   // Y = t2 + t3
  endtask

  task automatic test_reset();
    check(dataOut == 2'b00, "R6", dataOut, 0);
    check(cfgValid == 1'b0, "R6", cfgValid, 0);
    check(cfgErr == 1'b0, "R8", cfgErr, 0);
  endtask

  task automatic test_partial_load();
    wr(0, 6'b000_011, 1'b0);
    wr(1, 6'b100_001, 1'b0);
    wr(2, 6'b010_001, 1'b0);
    wr(3, 6'b100_010, 1'b0);
    wr(4, 6'b0_0011, 1'b0);
    check(cfgValid == 1'b0, "R6", cfgValid, 0);
    @(negedge clk); dataIn = 3'b011; evalEn = 1'b1;
    @(negedge clk); evalEn = 1'b0;
    check(dataOut == 2'b00, "R6", dataOut, 0);
    wr(5, 6'b0_1100, 1'b0);
    check(cfgValid == 1'b1, "R6", cfgValid, 1);
  endtask

  task automatic test_reference();
    // R10 truth table of X=A·B+A·C', Y=A·B'+B·C'; also exercises R1 and R3
    logic [1:0] want;
    for (int x = 0; x < 8; x++) begin
      logic a, b, c;
      a = x[0]; b = x[1]; c = x[2];
      want = {(a & ~b) | (b & ~c), (a & b) | (a & ~c)};
      @(negedge clk); dataIn = 3'(x); palMode = 1'b0; evalEn = 1'b1;
      @(negedge clk); evalEn = 1'b0;
      check(dataOut == want, "R10", dataOut, want);
    end
    eval_all(1'b0, "R1");
  endtask

  task automatic test_busy_write();
    wr(0, 6'b000_000, 1'b1);  // R7: must not land
    check(cfgErr == 1'b0, "R7", cfgErr, 0);
    eval_all(1'b0, "R7");
  endtask

  task automatic test_range();
    wr(7, 6'b111_111, 1'b0);
    check(cfgErr == 1'b1, "R8", cfgErr, 1);
    @(negedge clk);
    check(cfgErr == 1'b0, "R8", cfgErr, 0);
    eval_all(1'b0, "R8");
  endtask

  task automatic test_hold();
    logic [1:0] prev;
    eval_one(3'b011, 1'b0, "R9");
    prev = dataOut;
    @(negedge clk); dataIn = 3'b000; evalEn = 1'b0;
    @(negedge clk);
    check(dataOut == prev, "R9", dataOut, prev);
    check(prev == 2'b11, "R9", prev, 3);
  endtask

  task automatic test_pal();
    wr(4, 6'b0_1100, 1'b0);  // X from t2,t3 in full mode
    wr(5, 6'b0_0011, 1'b0);  // Y from t0,t1 in full mode
    eval_all(1'b0, "R3");
    eval_all(1'b1, "R4");
  endtask

  task automatic test_polarity();
    wr(4, 6'b1_0011, 1'b0);
    wr(5, 6'b0_1100, 1'b0);
    eval_all(1'b0, "R5");
  endtask

  task automatic test_term_edges();
    wr(3, 6'b000_000, 1'b0);  // empty term: always 1
    eval_all(1'b0, "R2");
    wr(3, 6'b001_001, 1'b0);  // A and A': always 0
    eval_all(1'b0, "R2");
    wr(5, 6'b0_0000, 1'b0);   // empty output row
    eval_all(1'b0, "R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_partial_load();
    test_reference();
    test_busy_write();
    test_range();
    test_hold();
    test_pal();
    load_reference();
    test_polarity();
    test_term_edges();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule